// File: doc/BRIEF.md
# Serial DAC Front End with Daisy-Chain Pass-Through

This block is the digital input side of a two-channel, 10-bit digital-to-analog converter. A host sends 16-bit words over a three-wire serial link: a data line, a bit clock and an active-low frame strobe. Each accepted word is written into one of two per-channel holding registers. The channel is chosen by the top bit of the word. A shared, active-low load strobe copies both holding registers into the output registers at the same moment. The two 10-bit output registers are the block's outputs. They would drive the converter cores, which are not part of this block.

A static mode input picks how a frame ends. In single-device mode the block takes exactly the first sixteen bit clocks of a frame and ignores any that follow. In chain mode every bit clock shifts. Bits pushed out of the top of the shift register go to a registered serial output, which feeds the data input of the next device. The word is then taken from the last sixteen bits when the frame strobe rises. All serial pins and the load strobe are sampled by a faster system clock through synchronizer flops. Edges are found in that clock domain.

Top module: `sdac_serial_front`

## Requirements
- R1: After reset, both output registers read zero and the serial output is low.
- R2: In single-device mode, the sixteenth rising bit clock of a frame (frame strobe low) accepts the word. Bits arrive most significant first. Word bit 15 picks the channel (0 = channel A, 1 = channel B), bits 11:2 carry the code, and bits 14:12 and 1:0 have no effect.
- R3: In single-device mode, bit clocks after the sixteenth in the same frame neither shift nor cause a second write.
- R4: In single-device mode, a frame that ends with fewer than sixteen bit clocks writes nothing.
- R5: Bit clocks that arrive while the frame strobe is high do not shift the register.
- R6: In chain mode, every rising bit clock in a frame shifts. When the frame strobe rises, the last sixteen bits received are accepted with the same field layout as R2.
- R7: In chain mode, the serial output changes only after a falling bit clock, and then takes the register's top bit. Just before rising bit clock 16+k, it therefore shows the k-th bit of the frame.
- R8: In single-device mode the serial output stays low.
- R9: The output registers change only while the load strobe is low. While it is low, both follow their holding registers.
- R10: In chain mode, a frame of fewer than sixteen bit clocks writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial bit clock, asynchronous |
| sync_n_i | input | 1 | Active-low frame strobe, asynchronous |
| din_i | input | 1 | Serial data, most significant bit first |
| ldac_n_i | input | 1 | Active-low, level-sensitive output load strobe |
| chain_en_i | input | 1 | Mode select: 1 = chain, 0 = single-device (static) |
| sdo_o | output | 1 | Registered serial pass-through output |
| dac_a_o | output | 10 | Channel A output register |
| dac_b_o | output | 10 | Channel B output register |

## Verification
The bench builds the block with its default two-stage synchronizer. Its bit clock half period is six system cycles, so every bit-clock edge is seen and acted on before the next one arrives. With these values, frames of 8 to 40 bits are tried in both modes. This covers short frames, exact frames, single-device overrun and chain pass-through of up to 24 surplus bits. At the same timing, the serial output can be compared bit by bit against the stream that was sent.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int FRAME_W  = 16;
    localparam int CODE_W   = 10;
    localparam int SEL_BIT  = 15;
    localparam int CODE_LSB = 2;
    localparam int CNT_W    = $clog2(FRAME_W + 1);
    localparam int N_CH     = 2;

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [CNT_W-1:0]   bitcnt_t;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    typedef struct packed {
        chan_e ch;
        code_t code;
    } load_t;

    // Pin bundle order used by the synchronizer
    typedef struct packed {
        logic sclk;
        logic sync_n;
        logic din;
        logic ldac_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, sync_n: 1'b1, din: 1'b0, ldac_n: 1'b1};

    function automatic load_t decode_frame(input frame_t w);
        load_t r;
        r.ch   = chan_e'(w[SEL_BIT]);
        r.code = w[CODE_LSB +: CODE_W];
        return r;
    endfunction

endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
    parameter int            W        = 4,
    parameter int            N_STAGES = 2,
    parameter logic [W-1:0]  RST_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] stg [N_STAGES];
    logic [W-1:0] prev_q;

    generate
        for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= stg[N_STAGES-1];
    end

    assign q_o    = stg[N_STAGES-1];
    assign rise_o = stg[N_STAGES-1] & ~prev_q;
    assign fall_o = ~stg[N_STAGES-1] & prev_q;

endmodule

// File: rtl/sdac_frame_shifter.sv
module sdac_frame_shifter
    import sdac_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    chain_en_i,
    input  logic    sclk_rise_i,
    input  logic    sclk_fall_i,
    input  logic    sync_n_i,
    input  logic    sync_rise_i,
    input  logic    sync_fall_i,
    input  logic    din_i,
    output logic    shift_o,
    output logic    commit_o,
    output frame_t  word_o,
    output bitcnt_t cnt_o,
    output logic    sdo_o
);

    localparam bitcnt_t FULL = bitcnt_t'(FRAME_W);
    localparam bitcnt_t LAST = bitcnt_t'(FRAME_W - 1);

    frame_t  sr_q, sr_next;
    bitcnt_t cnt_q;
    logic    sdo_q;
    logic    gate_open;

    always_comb begin
        gate_open = chain_en_i || (cnt_q < FULL);
        shift_o   = sclk_rise_i && !sync_n_i && gate_open;
        sr_next   = {sr_q[FRAME_W-2:0], din_i};
        commit_o  = 1'b0;
        word_o    = sr_q;
        if (chain_en_i) begin
            // chain: word is the last sixteen bits, taken at frame end
            if (sync_rise_i && cnt_q == FULL) commit_o = 1'b1;
        end else begin
            // single device: word taken on its sixteenth bit
            if (shift_o && cnt_q == LAST) begin
                commit_o = 1'b1;
                word_o   = sr_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
            sdo_q <= 1'b0;
        end else begin
            if (sync_fall_i) begin
                cnt_q <= '0;
            end else if (shift_o && cnt_q < FULL) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (shift_o) sr_q <= sr_next;
            if (!chain_en_i)      sdo_q <= 1'b0;
            else if (sclk_fall_i) sdo_q <= sr_q[FRAME_W-1];
        end
    end

    assign cnt_o = cnt_q;
    assign sdo_o = sdo_q;

endmodule

// File: rtl/sdac_reg_bank.sv
module sdac_reg_bank
    import sdac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   commit_i,
    input  frame_t word_i,
    input  logic   ldac_act_i,
    output logic   wr_a_o,
    output logic   wr_b_o,
    output code_t  dac_a_o,
    output code_t  dac_b_o
);

    load_t      ld;
    logic       wr    [N_CH];
    code_t      hold_q[N_CH];
    code_t      out_q [N_CH];

    assign ld = decode_frame(word_i);

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            assign wr[c] = commit_i && (ld.ch == chan_e'(c));

            always_ff @(posedge clk) begin
                if (rst) begin
                    hold_q[c] <= '0;
                    out_q[c]  <= '0;
                end else begin
                    if (wr[c])      hold_q[c] <= ld.code;
                    if (ldac_act_i) out_q[c]  <= hold_q[c];
                end
            end
        end
    endgenerate

    assign wr_a_o  = wr[0];
    assign wr_b_o  = wr[1];
    assign dac_a_o = out_q[0];
    assign dac_b_o = out_q[1];

endmodule

// File: rtl/sdac_serial_front.sv
module sdac_serial_front
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              sync_n_i,
    input  logic              din_i,
    input  logic              ldac_n_i,
    input  logic              chain_en_i,
    output logic              sdo_o,
    output logic [CODE_W-1:0] dac_a_o,
    output logic [CODE_W-1:0] dac_b_o
);

    pins_t   pin_raw, pin_q, pin_rise, pin_fall;
    logic    shift, commit, wr_a, wr_b, ldac_act;
    frame_t  word;
    bitcnt_t cnt;

    assign pin_raw = '{sclk: sclk_i, sync_n: sync_n_i, din: din_i, ldac_n: ldac_n_i};

    sdac_pin_sync #(
        .W        ($bits(pins_t)),
        .N_STAGES (SYNC_STAGES),
        .RST_VAL  (PINS_IDLE)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_i    (pin_raw),
        .q_o    (pin_q),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    assign ldac_act = !pin_q.ldac_n;

    sdac_frame_shifter u_shift (
        .clk         (clk),
        .rst         (rst),
        .chain_en_i  (chain_en_i),
        .sclk_rise_i (pin_rise.sclk),
        .sclk_fall_i (pin_fall.sclk),
        .sync_n_i    (pin_q.sync_n),
        .sync_rise_i (pin_rise.sync_n),
        .sync_fall_i (pin_fall.sync_n),
        .din_i       (pin_q.din),
        .shift_o     (shift),
        .commit_o    (commit),
        .word_o      (word),
        .cnt_o       (cnt),
        .sdo_o       (sdo_o)
    );

    sdac_reg_bank u_regs (
        .clk        (clk),
        .rst        (rst),
        .commit_i   (commit),
        .word_i     (word),
        .ldac_act_i (ldac_act),
        .wr_a_o     (wr_a),
        .wr_b_o     (wr_b),
        .dac_a_o    (dac_a_o),
        .dac_b_o    (dac_b_o)
    );

endmodule

// File: rtl/sdac_serial_front_chk.sv
module sdac_serial_front_chk
    import sdac_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    chain_en,
    input logic    sclk_fall,
    input logic    sync_hi,
    input logic    shift,
    input logic    wr_a,
    input logic    wr_b,
    input logic    ldac_act,
    input bitcnt_t cnt,
    input logic    sdo,
    input code_t   dac_a,
    input code_t   dac_b
);

    AST_DAC_A_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ldac_act |=> $stable(dac_a));                                   // R9
    AST_DAC_B_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ldac_act |=> $stable(dac_b));                                   // R9
    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (rst)
        !chain_en |=> !sdo);                                             // R8
    AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (chain_en && !sclk_fall) |=> $stable(sdo));                      // R7
    AST_CNT_CAP: assert property (@(posedge clk) disable iff (rst)
        cnt <= bitcnt_t'(FRAME_W));                                      // R3
    AST_NO_EXTRA_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (!chain_en && cnt == bitcnt_t'(FRAME_W)) |-> !shift);            // R3
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_a, wr_b}));                                         // R2
    AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        sync_hi |-> !shift);                                             // R5

endmodule

bind sdac_serial_front sdac_serial_front_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .chain_en  (chain_en_i),
    .sclk_fall (pin_fall.sclk),
    .sync_hi   (pin_q.sync_n),
    .shift     (shift),
    .wr_a      (wr_a),
    .wr_b      (wr_b),
    .ldac_act  (ldac_act),
    .cnt       (cnt),
    .sdo       (sdo_o),
    .dac_a     (dac_a_o),
    .dac_b     (dac_b_o)
);

// File: tb/sdac_serial_front_tb.sv
module sdac_serial_front_tb;

    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0, sync_n = 1'b1, din = 1'b0, ldac_n = 1'b1, chain_en = 1'b0;
    logic       sdo;
    logic [9:0] dac_a, dac_b;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    logic       cap [1:64];
    logic [9:0] exp_in_a = '0, exp_in_b = '0, exp_a = '0, exp_b = '0;

    always #5 clk = ~clk;

    sdac_serial_front u_dut (
        .clk        (clk),
        .rst        (rst),
        .sclk_i     (sclk),
        .sync_n_i   (sync_n),
        .din_i      (din),
        .ldac_n_i   (ldac_n),
        .chain_en_i (chain_en),
        .sdo_o      (sdo),
        .dac_a_o    (dac_a),
        .dac_b_o    (dac_b)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // sends bits[n-1] first; records sdo just before each rising bit clock
    task automatic send(input logic [63:0] bits, input int n);
        sync_n = 1'b0;
        wait_clk(HALF);
        for (int j = 1; j <= n; j++) begin
            din = bits[n-j];
            wait_clk(HALF);
            cap[j] = sdo;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        sync_n = 1'b1;
        wait_clk(12);
    endtask

    function automatic logic [15:0] pick_word(input logic [63:0] bits, input int n, input bit chain);
        if (chain) return bits[15:0];
        return bits[n-1 -: 16];
    endfunction

    task automatic model(input logic [63:0] bits, input int n, input bit chain);
        logic [15:0] w;
        if (n < 16) return;
        w = pick_word(bits, n, chain);
        if (w[15]) exp_in_b = w[11:2];
        else       exp_in_a = w[11:2];
    endtask

    task automatic pulse_load();
        ldac_n = 1'b0;
        wait_clk(8);
        ldac_n = 1'b1;
        wait_clk(8);
        exp_a = exp_in_a;
        exp_b = exp_in_b;
    endtask

    task automatic check_outs(input string req);
        check({req, " dac_a"}, 32'(dac_a), 32'(exp_a));
        check({req, " dac_b"}, 32'(dac_b), 32'(exp_b));
    endtask

    task automatic check_chain_sdo(input logic [63:0] bits, input int n);
        for (int k = 17; k <= n; k++)
            check("R7 sdo stream", 32'(cap[k]), 32'(bits[n-(k-16)]));
    endtask

    task automatic run_frame(input logic [63:0] bits, input int n, input bit chain);
        chain_en = chain;
        wait_clk(4);
        send(bits, n);
        model(bits, n, chain);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] b;
        int          n;
        bit          ch;
        void'($urandom(32'd20240611));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);

        // R1 reset state
        check("R1 dac_a", 32'(dac_a), 0);
        check("R1 dac_b", 32'(dac_b), 0);
        check("R1 sdo", 32'(sdo), 0);

        // R2 single-device word to channel A, reserved/pad bits set
        run_frame(64'({1'b0, 3'b111, 10'h2A5, 2'b11}), 16, 1'b0);
        pulse_load();
        check_outs("R2 chan A");

        // R2 channel B, R3 eight surplus clocks ignored
        run_frame(64'({1'b1, 3'b000, 10'h13C, 2'b00, 8'hFF}), 24, 1'b0);
        pulse_load();
        check_outs("R3 overrun");
        check("R8 sdo single", 32'(sdo), 0);

        // R9 no load strobe: outputs hold
        run_frame(64'({1'b0, 3'b000, 10'h3FF, 2'b00}), 16, 1'b0);
        check_outs("R9 hold");
        pulse_load();
        check_outs("R9 load");

        // R4 short frame discarded
        run_frame(64'({9'h1AB}), 9, 1'b0);
        pulse_load();
        check_outs("R4 short");

        // R6 + R7 chain, 32 bits
        b = 64'h0000_0000_A5C3_8D54;
        run_frame(b, 32, 1'b1);
        check_chain_sdo(b, 32);
        pulse_load();
        check_outs("R6 chain32");

        // R5 idle clocks while strobe high; position 5 is 0, positions 6..9 are 1
        b = 64'({4'b1010, 1'b0, 4'b1111, 11'h0F0});
        run_frame(b, 20, 1'b1);
        din = 1'b1;
        for (int p = 0; p < 5; p++) begin
            wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
        end
        wait_clk(HALF);
        check("R5 sdo after idle clocks", 32'(sdo), 0);
        pulse_load();
        check_outs("R5 word after idle clocks");

        // R10 short chain frame discarded
        run_frame(64'(12'hFFF), 12, 1'b1);
        pulse_load();
        check_outs("R10 short chain");

        // random mix
        for (int it = 0; it < 40; it++) begin
            n  = 8 + int'($urandom % 33);
            ch = bit'($urandom % 2);
            b  = {$urandom, $urandom};
            run_frame(b, n, ch);
            if (ch && n > 16) check_chain_sdo(b, n);
            if (!ch) check("R8 sdo random", 32'(sdo), 0);
            if ($urandom % 2) pulse_load();
            check_outs(ch ? "R6 R9 R10 random" : "R2 R3 R4 R9 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule